// File: doc/BRIEF.md
# Low-Voltage Event Pending Controller

This block collects low-voltage warnings from two supply monitors, one on the high-voltage ADC supply and one on the high-voltage main I/O supply. Each warning enters through a two-flop synchronizer. Its rising edge latches a pending flag in a 32-bit status word, and software clears that flag by writing one to it.

Each source has three settings: an interrupt enable, a reset enable and a reset-kind select. A pending flag with its interrupt enabled raises a registered interrupt line. A pending flag with its reset enabled causes one of two things, each lasting a single cycle: a functional reset request pulse or a destructive reset request pulse. That reset clears the flag and keeps the interrupt from asserting.

The reset enables are set at boot through a load strobe. Once a reset enable bit is set, nothing clears it until hardware reset.

Top module: `lv_event_ctrl`

## Requirements
- R1: After reset, every register reads zero and `irq`, `rst_func_req` and `rst_dest_req` are low.
- R2: Register addresses are 0 status, 1 interrupt enable, 2 reset enable and 3 reset select. In every register the ADC source sits at data bit 22 and the main I/O source sits at data bit 21, which are positions 9 and 10 when counted from the most significant bit. All other bits read zero.
- R3: A rising edge on a detect input sets its flag. The flag reads 1 on the third rising clock edge after the input rises, and not earlier. Holding the input high does not set the flag again after it has been cleared.
- R4: Writing 1 to a status flag bit clears that flag. Writing 0 leaves the flag unchanged.
- R5: If a new detection and a write-one-to-clear reach the same flag in the same cycle, the flag stays set.
- R6: `irq` is registered, one cycle behind, and equals the OR over both sources of the flag ANDed with its interrupt enable.
- R7: A reset enable bit is set by `boot_load` with `boot_rst_en` (bit 0 is ADC, bit 1 is main I/O) or by a software write of 1. Once set, neither source can clear it.
- R8: A pending flag whose reset is enabled produces a reset pulse one cycle later. The pulse lasts one cycle. The flag is cleared in that same cycle, and `irq` does not assert for that flag.
- R9: A reset select bit of 1 produces `rst_dest_req`. A reset select bit of 0 produces `rst_func_req`.
- R10: If both sources request a reset in the same cycle with different selects, only `rst_dest_req` pulses.
- R11: Interrupt enable and reset select read back what was last written, at the source bit positions only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| det_adc | input | 1 | Asynchronous low-voltage detect, ADC supply |
| det_io | input | 1 | Asynchronous low-voltage detect, main I/O supply |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| boot_load | input | 1 | Boot-time reset-enable load strobe |
| boot_rst_en | input | 2 | Boot value for the reset enables |
| irq | output | 1 | Low-voltage interrupt |
| rst_func_req | output | 1 | Functional reset request pulse |
| rst_dest_req | output | 1 | Destructive reset request pulse |

## Verification
Detections are driven on the ADC source alone, on the main I/O source alone, and on both sources together. This shows whether each flag lands at its own bit position and whether each source is gated by its own enable.

Clears are written as all zeros, as the other source's bit, and as the source's own bit. This separates a true write-one-to-clear from a write that clears everything or clears the wrong source. A clear is also timed to land in the same cycle as a fresh detection to confirm that the detection wins.

Reset requests are tried with a functional select, with a destructive select, and with two simultaneous sources whose selects differ. These cases check the pulse kind, the one-cycle pulse width, the flag clearing and the destructive priority.

// File: rtl/lv_pkg.sv
package lv_pkg;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 2;
  localparam int NUM_SRC   = 2;
  localparam int SYNC_STG  = 2;
  // Source 0 (ADC supply) sits at MSB-first position 9, source 1 at 10.
  localparam int MSB0_BASE = 9;

  typedef enum logic [ADDR_W-1:0] {
    REG_STATUS  = 2'd0,
    REG_IRQ_EN  = 2'd1,
    REG_RST_EN  = 2'd2,
    REG_RST_SEL = 2'd3
  } reg_addr_e;

  function automatic int flag_lsb(int src);
    return DATA_W - 1 - MSB0_BASE - src;
  endfunction

  function automatic logic [DATA_W-1:0] to_word(logic [NUM_SRC-1:0] v);
    logic [DATA_W-1:0] w;
    w = '0;
    for (int s = 0; s < NUM_SRC; s++) w[flag_lsb(s)] = v[s];
    return w;
  endfunction

  function automatic logic [NUM_SRC-1:0] from_word(logic [DATA_W-1:0] w);
    logic [NUM_SRC-1:0] v;
    for (int s = 0; s < NUM_SRC; s++) v[s] = w[flag_lsb(s)];
    return v;
  endfunction
endpackage

// File: rtl/lv_sync.sv
module lv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] sh;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      prev <= 1'b0;
    end else begin
      sh   <= {sh[STAGES-2:0], async_in};
      prev <= sh[STAGES-1];
    end
  end

  assign rise = sh[STAGES-1] & ~prev;
endmodule

// File: rtl/lv_flag_bank.sv
module lv_flag_bank #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_evt,
  input  logic [N-1:0] clr_w1c,
  input  logic [N-1:0] rst_en,
  output logic [N-1:0] take,
  output logic [N-1:0] flag
);
  logic [N-1:0] flag_n;

  assign take = flag & rst_en;

  // A fresh detection overrides both a software clear and a reset take.
  always_comb flag_n = set_evt | (flag & ~clr_w1c & ~take);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= '0;
    else        flag <= flag_n;
  end
endmodule

// File: rtl/lv_req_gen.sv
module lv_req_gen #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] flag,
  input  logic [N-1:0] irq_en,
  input  logic [N-1:0] take,
  input  logic [N-1:0] rst_sel,
  output logic         irq,
  output logic         rst_func_req,
  output logic         rst_dest_req
);
  logic want_dest, want_func;

  assign want_dest = |(take & rst_sel);
  assign want_func = |(take & ~rst_sel) & ~want_dest;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq          <= 1'b0;
      rst_func_req <= 1'b0;
      rst_dest_req <= 1'b0;
    end else begin
      irq          <= |(flag & irq_en & ~take);
      rst_func_req <= want_func;
      rst_dest_req <= want_dest;
    end
  end
endmodule

// File: rtl/lv_event_ctrl.sv
module lv_event_ctrl
  import lv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              det_adc,
  input  logic              det_io,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              boot_load,
  input  logic [NUM_SRC-1:0] boot_rst_en,
  output logic              irq,
  output logic              rst_func_req,
  output logic              rst_dest_req
);
  logic [NUM_SRC-1:0] det_in, det_rise, flag_q, take;
  logic [NUM_SRC-1:0] irq_en_q, rst_en_q, rst_sel_q, rst_en_n;
  logic [NUM_SRC-1:0] wr_bits, clr_w1c;
  logic               unused_wdata;

  assign det_in  = {det_io, det_adc};
  assign wr_bits = from_word(bus_wdata);
  assign clr_w1c = (bus_we && bus_addr == REG_STATUS) ? wr_bits : '0;
  assign unused_wdata = ^(bus_wdata & ~to_word('1));

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_sync
    lv_sync #(.STAGES(SYNC_STG)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(det_in[s]), .rise(det_rise[s])
    );
  end

  lv_flag_bank #(.N(NUM_SRC)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_evt(det_rise), .clr_w1c(clr_w1c),
    .rst_en(rst_en_q), .take(take), .flag(flag_q)
  );

  // Reset enables only ever accumulate set bits.
  always_comb begin
    rst_en_n = rst_en_q;
    if (boot_load) rst_en_n = rst_en_n | boot_rst_en;
    if (bus_we && bus_addr == REG_RST_EN) rst_en_n = rst_en_n | wr_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en_q  <= '0;
      rst_sel_q <= '0;
      rst_en_q  <= '0;
    end else begin
      rst_en_q <= rst_en_n;
      if (bus_we && bus_addr == REG_IRQ_EN)  irq_en_q  <= wr_bits;
      if (bus_we && bus_addr == REG_RST_SEL) rst_sel_q <= wr_bits;
    end
  end

  always_comb begin
    unique case (bus_addr)
      REG_STATUS:  bus_rdata = to_word(flag_q);
      REG_IRQ_EN:  bus_rdata = to_word(irq_en_q);
      REG_RST_EN:  bus_rdata = to_word(rst_en_q);
      default:     bus_rdata = to_word(rst_sel_q);
    endcase
  end

  lv_req_gen #(.N(NUM_SRC)) u_req (
    .clk(clk), .rst_n(rst_n), .flag(flag_q), .irq_en(irq_en_q), .take(take),
    .rst_sel(rst_sel_q), .irq(irq), .rst_func_req(rst_func_req),
    .rst_dest_req(rst_dest_req)
  );
endmodule

// File: rtl/lv_event_ctrl_chk.sv
module lv_event_ctrl_chk
  import lv_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] rise,
  input logic [NUM_SRC-1:0] flag,
  input logic [NUM_SRC-1:0] take,
  input logic [NUM_SRC-1:0] rst_en,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic               irq,
  input logic               rst_func_req,
  input logic               rst_dest_req
);
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & ~to_word('1)) == '0);

  assert_rst_en_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_en & $past(rst_en)) == $past(rst_en));

  assert_rise_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((flag & $past(rise)) == $past(rise)));

  assert_take_clears_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(take & ~rise)) |=> ((flag & $past(take & ~rise)) == '0));

  assert_irq_needs_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(|flag));

  assert_one_reset_kind_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_func_req && rst_dest_req));

  assert_reset_needs_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_func_req || rst_dest_req) |-> $past(|take));
endmodule

bind lv_event_ctrl lv_event_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rise(det_rise), .flag(flag_q), .take(take),
  .rst_en(rst_en_q), .bus_rdata(bus_rdata), .irq(irq),
  .rst_func_req(rst_func_req), .rst_dest_req(rst_dest_req)
);

// File: tb/tb_lv_event_ctrl.sv
`timescale 1ns/100ps
module tb_lv_event_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        det_adc = 1'b0, det_io = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        boot_load = 1'b0;
  logic [1:0]  boot_rst_en = 2'b00;
  logic        irq, rst_func_req, rst_dest_req;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  localparam logic [31:0] B_ADC = 32'h0040_0000; // bit 22
  localparam logic [31:0] B_IO  = 32'h0020_0000; // bit 21

  always #2.5 clk = ~clk;

  lv_event_ctrl dut (
    .clk(clk), .rst_n(rst_n), .det_adc(det_adc), .det_io(det_io),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .boot_load(boot_load), .boot_rst_en(boot_rst_en),
    .irq(irq), .rst_func_req(rst_func_req), .rst_dest_req(rst_dest_req)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  function automatic logic [31:0] rd(logic [1:0] a);
    bus_addr = a;
    return bus_rdata;
  endfunction

  task automatic rdchk(string req, logic [1:0] a, logic [31:0] exp);
    bus_addr = a;
    #0.5;
    check(req, bus_rdata, exp);
  endtask

  task automatic settle();
    det_adc = 1'b0; det_io = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    rdchk("R1 status", 2'd0, 32'h0);
    rdchk("R1 irq_en", 2'd1, 32'h0);
    rdchk("R1 rst_en", 2'd2, 32'h0);
    rdchk("R1 rst_sel", 2'd3, 32'h0);
    check("R1 outputs", {29'd0, irq, rst_func_req, rst_dest_req}, 32'h0);
  endtask

  task automatic t_regs();
    wr(2'd1, 32'hFFFF_FFFF);
    rdchk("R11 R2 irq_en readback", 2'd1, B_ADC | B_IO);
    wr(2'd3, B_IO | 32'h0000_0001);
    rdchk("R11 R2 rst_sel readback", 2'd3, B_IO);
    wr(2'd1, 32'h0);
    wr(2'd3, 32'h0);
    rdchk("R11 irq_en cleared", 2'd1, 32'h0);
  endtask

  task automatic t_set_clear();
    @(negedge clk); det_adc = 1'b1;
    repeat (2) @(negedge clk);
    rdchk("R3 not yet set", 2'd0, 32'h0);
    @(negedge clk);
    rdchk("R3 R2 adc flag set", 2'd0, B_ADC);
    wr(2'd0, 32'h0);
    rdchk("R4 write zero keeps", 2'd0, B_ADC);
    wr(2'd0, B_IO);
    rdchk("R4 other bit keeps", 2'd0, B_ADC);
    wr(2'd0, B_ADC);
    rdchk("R4 w1c clears", 2'd0, 32'h0);
    repeat (4) @(negedge clk);
    rdchk("R3 level does not reset", 2'd0, 32'h0);
    settle();
  endtask

  task automatic t_irq();
    wr(2'd1, B_ADC);
    @(negedge clk); det_io = 1'b1;
    repeat (3) @(negedge clk);
    rdchk("R2 io flag position", 2'd0, B_IO);
    @(negedge clk);
    check("R6 io masked", {31'd0, irq}, 32'd0);
    det_adc = 1'b1;
    repeat (3) @(negedge clk);
    check("R6 irq not before register", {31'd0, irq}, 32'd0);
    @(negedge clk);
    check("R6 irq asserts", {31'd0, irq}, 32'd1);
    wr(2'd0, B_ADC);
    check("R6 irq lags clear", {31'd0, irq}, 32'd1);
    @(negedge clk);
    check("R6 irq drops", {31'd0, irq}, 32'd0);
    wr(2'd0, B_IO);
    wr(2'd1, 32'h0);
    settle();
  endtask

  task automatic t_race();
    @(negedge clk); det_adc = 1'b1;
    repeat (4) @(negedge clk);
    det_adc = 1'b0;
    repeat (5) @(negedge clk);
    rdchk("R5 flag held before race", 2'd0, B_ADC);
    @(negedge clk); det_adc = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_addr = 2'd0; bus_wdata = B_ADC; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
    rdchk("R5 detect beats clear", 2'd0, B_ADC);
    wr(2'd0, B_ADC);
    rdchk("R5 later clear works", 2'd0, 32'h0);
    settle();
  endtask

  task automatic t_reset_req();
    wr(2'd1, B_ADC | B_IO);
    @(negedge clk); boot_load = 1'b1; boot_rst_en = 2'b01;
    @(negedge clk); boot_load = 1'b0; boot_rst_en = 2'b00;
    rdchk("R7 boot load", 2'd2, B_ADC);
    wr(2'd2, 32'h0);
    rdchk("R7 cannot clear", 2'd2, B_ADC);
    @(negedge clk); det_adc = 1'b1;
    repeat (3) @(negedge clk);
    rdchk("R8 flag pending", 2'd0, B_ADC);
    check("R8 no pulse yet", {30'd0, rst_func_req, rst_dest_req}, 32'd0);
    @(negedge clk);
    rdchk("R8 flag cleared by reset", 2'd0, 32'h0);
    check("R9 functional pulse", {30'd0, rst_func_req, rst_dest_req}, 32'd2);
    check("R8 irq stays low", {31'd0, irq}, 32'd0);
    @(negedge clk);
    check("R8 pulse one cycle", {30'd0, rst_func_req, rst_dest_req}, 32'd0);
    settle();
    wr(2'd3, B_ADC);
    @(negedge clk); det_adc = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 destructive pulse", {30'd0, rst_func_req, rst_dest_req}, 32'd1);
    @(negedge clk);
    check("R9 destructive one cycle", {30'd0, rst_func_req, rst_dest_req}, 32'd0);
    settle();
  endtask

  task automatic t_both();
    wr(2'd2, B_IO);
    rdchk("R7 software set", 2'd2, B_ADC | B_IO);
    @(negedge clk); det_adc = 1'b1; det_io = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 destructive wins", {30'd0, rst_func_req, rst_dest_req}, 32'd1);
    rdchk("R8 both flags cleared", 2'd0, 32'h0);
    settle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_set_clear();
    t_irq();
    t_race();
    t_reset_req();
    t_both();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule